// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external bus transfer at a time for a small CPU core. The external bus has 20 address bits and 16 data bits, and the low 16 address bits share their pins with the data. The core posts a single request that carries the address, the write data, the direction, a memory-or-port flag, a byte-or-word size and a two-bit code for the active segment. The sequencer then steps through four bus states: T1, T2, T3 and T4. It adds wait states after T3 for as long as the addressed device holds `ready` low.

In T1 the shared lines carry the address, and `ale` tells external latches to capture it. From T2 to T4 the shared lines carry data, and the upper four lines carry status: the interrupt-enable flag and the segment code. The byte-lane pin and address bit 0 together select which half of the data bus takes part. In a read, the shared lines are released before the read strobe falls. The returned data is captured on the edge that ends the last T3 or wait state, moved to the low byte when the access is a byte, and held for the core. A one-cycle done pulse in T4 marks the end of the transfer.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst_n` is low and after reset, the block is idle: `ad_oe`=0, `ale`=0, `den`=0, `rd_n`=1, `wr_n`=1, `bhe_n`=1, `busy`=0, `rsp_done`=0, `rsp_rdata`=0.
- R2: A request sampled with `req_valid`=1 while idle is followed by T1, T2 and T3, one clock each. Without wait states, the next cycle is T4, with `rsp_done`=1 for exactly that one cycle. The block is idle in the cycle after T4, and `busy` is 1 from T1 through T4.
- R3: In T1 only, `ale`=1, `ad_oe`=1 and `ad_out` equals address bits 15..0. `ale` is 0 in every other state.
- R4: In T1, `ah_out` carries address bits 19..16 for a memory cycle (`req_io`=0) and is 0 for a port cycle (`req_io`=1).
- R5: From T2 to T4, `ah_out` is {bit3=0, bit2=`int_en` as currently driven, bits1..0=segment code}, with code 00 extra, 01 stack, 10 code/none and 11 data. `bhe_n` reads 0 in these states because the S7 status is held at zero.
- R6: In T1, `bhe_n` = NOT(word OR A0). The pair (`bhe_n`, A0) then means: 00 whole word, 01 upper byte at an odd address, 10 lower byte at an even address, 11 no lanes. A word request at an odd address uses the upper lane only.
- R7: In a read, `ad_oe`=0 from T2 to T4, and `rd_n`=0 only in T2, T3 and wait states. `rd_n` is never 0 while `ad_oe`=1.
- R8: In a write, `ad_oe`=1 from T2 to T4 and `ad_out` carries the write data. A byte write places bits 7..0 on both lanes. `wr_n`=0 in T2, T3 and wait states, and `wr_n`=1 in T4. `rd_n` and `wr_n` are never low together.
- R9: `ready` is sampled without synchronization, and only on the edge that ends T3 or a wait state. A low sample adds one wait state. A high `ready` during T1 or T2 does not shorten the cycle.
- R10: Read data is taken from `ad_in` on the edge that ends the last T3 or wait state. A word read gives `ad_in` unchanged, an even-byte read gives {8'h00, `ad_in`[7:0]} and an odd-byte read gives {8'h00, `ad_in`[15:8]}. `rsp_rdata` holds this value until the next read completes, and write cycles do not change it.
- R11: `den`=1 from T2 to T4 and `den`=0 in idle and T1.
- R12: `req_valid` and the request fields are ignored while `busy`=1. The running cycle keeps the address, status and data that were latched at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core posts a transfer (taken only when idle) |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port space, 0 = memory |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_seg | input | 2 | Active segment code |
| int_en | input | 1 | Interrupt-enable flag reported in status |
| ready | input | 1 | Device acknowledge, active high |
| ad_in | input | 16 | Value seen on the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| ah_out | output | 4 | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Upper-lane enable (active low) in T1, S7 status afterwards |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den | output | 1 | Data transceiver enable |
| rsp_rdata | output | 16 | Lane-aligned read data |
| rsp_done | output | 1 | One-cycle completion pulse in T4 |
| busy | output | 1 | A bus cycle is in progress |

## Verification
The collision that matters most is the data-capture edge meeting the end of the wait states. The same `ready` sample that ends the wait also stores `ad_in`. To test this, the bench drives the inverted data on `ad_in` in every earlier data-phase cycle. It presents the true value only in the cycle where it raises `ready`, so a capture one cycle early or late returns the wrong word. A second collision is a new request arriving while a cycle is still running: `req_valid` is held high with scrambled fields until T4. The bench then checks the status and data lines, and that the block goes idle after the done pulse.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_st_e;

    localparam logic [1:0] SEG_EXTRA = 2'b00;
    localparam logic [1:0] SEG_STACK = 2'b01;
    localparam logic [1:0] SEG_CODE  = 2'b10;
    localparam logic [1:0] SEG_DATA  = 2'b11;
endpackage

// File: rtl/mbs_lane.sv
// Byte-lane encoding, write-data steering and read-data alignment.
module mbs_lane #(
    parameter int DATA_W = 16
) (
    input  logic              word,
    input  logic              a0,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              bhe_n,
    output logic [DATA_W-1:0] wbus,
    output logic [DATA_W-1:0] rdata
);
    localparam int LANE_W = DATA_W / 2;

    always_comb begin
        bhe_n = ~(word | a0);
        wbus  = word ? wdata : {2{wdata[LANE_W-1:0]}};
        if (word) begin
            rdata = ad_in;
        end else if (a0) begin
            rdata = {{LANE_W{1'b0}}, ad_in[DATA_W-1:LANE_W]};
        end else begin
            rdata = {{LANE_W{1'b0}}, ad_in[LANE_W-1:0]};
        end
    end
endmodule

// File: rtl/mbs_pins.sv
// Decodes the registered bus state into pin values.
module mbs_pins import mux_bus_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  bus_st_e             st,
    input  logic                wr,
    input  logic                io,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wbus,
    input  logic                bhe_lane_n,
    input  logic [SEG_W-1:0]    seg,
    input  logic                int_en,
    output logic [DATA_W-1:0]   ad_out,
    output logic                ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                bhe_n,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic                den,
    output logic                done,
    output logic                busy
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [HI_W-1:0] status;

    always_comb begin
        status         = '0;
        status[SEG_W-1:0] = seg;
        status[SEG_W]  = int_en;

        ad_out = '0;
        ad_oe  = 1'b0;
        ah_out = '0;
        bhe_n  = 1'b1;
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        den    = 1'b0;
        done   = (st == ST_T4);
        busy   = (st != ST_IDLE);

        case (st)
            ST_T1: begin
                ad_out = addr[DATA_W-1:0];
                ad_oe  = 1'b1;
                ah_out = io ? '0 : addr[ADDR_W-1:DATA_W];
                bhe_n  = bhe_lane_n;
                ale    = 1'b1;
            end
            ST_T2, ST_T3, ST_TW: begin
                ad_out = wr ? wbus : '0;
                ad_oe  = wr;
                ah_out = status;
                bhe_n  = 1'b0;
                rd_n   = wr;
                wr_n   = ~wr;
                den    = 1'b1;
            end
            ST_T4: begin
                ad_out = wr ? wbus : '0;
                ad_oe  = wr;
                ah_out = status;
                bhe_n  = 1'b0;
                den    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mux_bus_seq.sv
// Bus cycle sequencer: T1, T2, T3, wait states, T4.
module mux_bus_seq import mux_bus_pkg::*; #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    input  logic                     req_io,
    input  logic                     req_word,
    input  logic [SEG_W-1:0]         req_seg,
    input  logic                     int_en,
    input  logic                     ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ah_out,
    output logic                     bhe_n,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_done,
    output logic                     busy
);
    typedef struct packed {
        bus_st_e           st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              io;
        logic              word;
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t              cur_q, nxt_d;
    bus_st_e           st_q;
    logic              bhe_lane_n;
    logic [DATA_W-1:0] wbus;
    logic [DATA_W-1:0] rd_aligned;

    assign st_q = cur_q.st;

    mbs_lane #(.DATA_W(DATA_W)) u_lane (
        .word  (cur_q.word),
        .a0    (cur_q.addr[0]),
        .wdata (cur_q.wdata),
        .ad_in (ad_in),
        .bhe_n (bhe_lane_n),
        .wbus  (wbus),
        .rdata (rd_aligned)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.st    = ST_T1;
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    nxt_d.wr    = req_write;
                    nxt_d.io    = req_io;
                    nxt_d.word  = req_word;
                    nxt_d.seg   = req_seg;
                end
            end
            ST_T1: nxt_d.st = ST_T2;
            ST_T2: nxt_d.st = ST_T3;
            ST_T3, ST_TW: begin
                if (ready) begin
                    nxt_d.st = ST_T4;
                    if (!cur_q.wr) begin
                        nxt_d.rdata = rd_aligned;
                    end
                end else begin
                    nxt_d.st = ST_TW;
                end
            end
            ST_T4:   nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_pins (
        .st         (st_q),
        .wr         (cur_q.wr),
        .io         (cur_q.io),
        .addr       (cur_q.addr),
        .wbus       (wbus),
        .bhe_lane_n (bhe_lane_n),
        .seg        (cur_q.seg),
        .int_en     (int_en),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe),
        .ah_out     (ah_out),
        .bhe_n      (bhe_n),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .den        (den),
        .done       (rsp_done),
        .busy       (busy)
    );

    assign rsp_rdata = cur_q.rdata;
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk import mux_bus_pkg::*; (
    input logic    clk,
    input logic    rst_n,
    input logic    ready,
    input logic    ad_oe,
    input logic    ale,
    input logic    rd_n,
    input logic    wr_n,
    input logic    den,
    input logic    rsp_done,
    input logic    busy,
    input bus_st_e st
);
    // R3
    ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);
    // R3
    ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe);
    // R7
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_n || wr_n);
    // R11
    den_cover_chk: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n || !wr_n) |-> den);
    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> (!rsp_done && !busy));
    // R2
    t1_step_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_T1) |=> (st == ST_T2));
    // R9
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T3 || st == ST_TW) && !ready) |=> (st == ST_TW));
    // R9
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_T3 || st == ST_TW) && ready) |=> rsp_done);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .ad_oe    (ad_oe),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .den      (den),
    .rsp_done (rsp_done),
    .busy     (busy),
    .st       (st_q)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_word = 1'b0;
    logic [1:0]  req_seg = '0;
    logic        int_en = 1'b0;
    logic        ready = 1'b0;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  ah_out;
    logic        bhe_n, ale, rd_n, wr_n, den, rsp_done, busy;
    logic [15:0] rsp_rdata;

    int n_run = 0;
    int n_fail = 0;
    logic [15:0] last_rd = '0;

    always #4 clk = ~clk;

    mux_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .req_word(req_word), .req_seg(req_seg), .int_en(int_en), .ready(ready),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .ah_out(ah_out),
        .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den(den),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .busy(busy)
    );

    typedef struct packed {
        logic [19:0] addr;
        logic [15:0] wdata;
        logic        wr;
        logic        io;
        logic        word;
        logic [1:0]  seg;
        logic        ie;
        logic [3:0]  waits;
        logic [15:0] rdin;
        logic        bhe;
        logic [3:0]  ah1;
        logic [15:0] exp;
    } vec_t;

    // exp: aligned read data for reads, bus data for writes
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{20'h51234, 16'h0000, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 4'd0, 16'hBEEF, 1'b0, 4'h5, 16'hBEEF},
        '{20'hA0010, 16'h0000, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 4'd2, 16'h1234, 1'b1, 4'hA, 16'h0034},
        '{20'hF0081, 16'h0000, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 4'd1, 16'hAB12, 1'b0, 4'h0, 16'h00AB},
        '{20'h34566, 16'hC0DE, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 4'd0, 16'h0000, 1'b0, 4'h3, 16'hC0DE},
        '{20'h70003, 16'h1299, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1, 4'd3, 16'h0000, 1'b0, 4'h7, 16'h9999},
        '{20'hC0042, 16'h00F0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 4'd0, 16'h0000, 1'b1, 4'h0, 16'hF0F0},
        '{20'h10001, 16'h0000, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 4'd0, 16'h5A5A, 1'b0, 4'h1, 16'h5A5A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 ad_oe"}, ad_oe, 0);
        chk({tag, " R1 ale"}, ale, 0);
        chk({tag, " R11 den"}, den, 0);
        chk({tag, " R1 rd_n"}, rd_n, 1);
        chk({tag, " R1 wr_n"}, wr_n, 1);
        chk({tag, " R1 bhe_n"}, bhe_n, 1);
        chk({tag, " R2 busy"}, busy, 0);
        chk({tag, " R2 done"}, rsp_done, 0);
    endtask

    task automatic chk_data(input vec_t v, input bit t4, input string tag);
        chk({tag, " R5 status"}, ah_out, {1'b0, v.ie, v.seg});
        chk({tag, " R5 S7"}, bhe_n, 0);
        chk({tag, " R3 ale"}, ale, 0);
        chk({tag, " R11 den"}, den, 1);
        chk({tag, " R7 R8 ad_oe"}, ad_oe, v.wr);
        if (v.wr) chk({tag, " R8 wdata"}, ad_out, v.exp);
        chk({tag, " R7 rd_n"}, rd_n, (t4 || v.wr) ? 1 : 0);
        chk({tag, " R8 wr_n"}, wr_n, (t4 || !v.wr) ? 1 : 0);
        chk({tag, " R2 R9 done"}, rsp_done, t4);
    endtask

    task automatic run_vec(input vec_t v, input bit hold);
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr; req_wdata = v.wdata; req_write = v.wr;
        req_io = v.io; req_word = v.word; req_seg = v.seg; int_en = v.ie;
        ready = 1'b1; ad_in = ~v.rdin;
        @(negedge clk); // T1
        req_valid = hold; req_addr = ~v.addr; req_wdata = ~v.wdata; req_write = ~v.wr;
        req_seg = ~v.seg; req_word = ~v.word; req_io = ~v.io;
        chk("T1 R3 ale", ale, 1);
        chk("T1 R3 ad_oe", ad_oe, 1);
        chk("T1 R3 addr", ad_out, v.addr[15:0]);
        chk("T1 R4 upper", ah_out, v.ah1);
        chk("T1 R6 bhe_n", bhe_n, v.bhe);
        chk("T1 R11 den", den, 0);
        chk("T1 R2 busy", busy, 1);
        @(negedge clk); // T2, ready high here must be ignored (R9)
        chk_data(v, 1'b0, "T2");
        for (int w = 0; w <= int'(v.waits); w++) begin
            @(negedge clk); // T3 then TW
            chk_data(v, 1'b0, "T3/TW R9 R12");
            ready = (w == int'(v.waits));
            ad_in = ready ? v.rdin : ~v.rdin;
        end
        @(negedge clk); // T4
        ad_in = 16'h0F0F; ready = 1'b0; req_valid = 1'b0;
        chk_data(v, 1'b1, "T4");
        if (!v.wr) last_rd = v.exp;
        chk("T4 R10 rdata", rsp_rdata, last_rd);
        @(negedge clk); // idle
        chk_idle("post R12");
        chk("post R10 held", rsp_rdata, last_rd);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("reset");
        chk("reset R1 rdata", rsp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("after reset");

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R12: request held high with other fields through the whole cycle
        run_vec(VECS[1], 1'b1);
        run_vec(VECS[4], 1'b1);

        // R1: reset in the middle of a read
        @(negedge clk);
        req_valid = 1'b1; req_addr = 20'h22222; req_write = 1'b0; req_word = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_idle("mid reset");
        chk("mid reset R1 rdata", rsp_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("mid reset after");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule